// File: doc/BRIEF.md
# Memory Pattern Self-Test Sequencer

This block exercises a single-port synchronous RAM with one of four classic pattern algorithms and reports whether every read returned the value the algorithm predicts. A pulse on `start` latches the algorithm code and the stop policy. The sequencer then issues one memory operation per clock, either a read or a write, with no idle cycles between operations. When the last comparison is complete it raises `done`.

The four algorithms are as follows:
- **Marching ones:** clear the array, then climb the addresses doing read-0/write-1, then descend doing read-1/write-0.
- **Marching zeros:** the same march with every data word inverted.
- **Checkerboard:** write an alternating-bit pattern that flips with the address parity, read it all back, then repeat with the complement.
- **Walking test:** for every pivot location, set the pivot, read every other location, verify the pivot and restore it. It runs once with a walking one over zeros, then with a walking zero over ones.

Read data returns one cycle after the read is issued. A pipeline register keeps the expected word and the address until the data comes back. The first mismatch sets `fail` and captures its address. The run then either halts at once or continues to the end, depending on `stop_on_fail`. The address width is a parameter, so the quadratic walking test can be kept small.

Top module: `mem_bist_ctrl`

## Requirements
- R1: While `rst` is high and after it falls, `done`, `fail` and `mem_we` are 0 until a start is accepted.
- R2: Mode 0 (marching ones) issues, in order: write 0 to addresses 0..N-1; then for each address 0..N-1 a read expecting 0 followed by a write of all ones; then for each address N-1 down to 0 a read expecting all ones followed by a write of 0.
- R3: Mode 1 (marching zeros) issues the same operation order as R2 with every written and expected word inverted.
- R4: Mode 2 (checkerboard) writes each address 0..N-1 and then reads each address 0..N-1, then repeats both loops with inverted data. In the first pass an even address holds a word with bit 0 set and alternating bits (0x55 for 8 bits), and an odd address holds its complement (0xAA).
- R5: Mode 3 (walking) fills with 0, then for each pivot p from 0 up does the following: write all ones at p; read every other address in ascending order expecting 0; read p expecting all ones; write 0 at p. It then repeats the fill and the whole pivot loop with all data inverted.
- R6: After the start is accepted, exactly one operation is presented per cycle, beginning in the next cycle. Read data is compared in the cycle after the read. One idle cycle follows the last operation, and `done` is 1 from the cycle after that.
- R7: The first read whose data differs from its expected word sets `fail` and records its address in `fail_addr`. Later mismatches in the same run change neither output.
- R8: With `stop_on_fail` = 1, the cycle after a mismatch is detected shows `done` = 1 and issues no further operations.
- R9: A `start` pulse during a run has no effect on the operation stream. A start accepted after `done` clears `fail` and begins the newly selected algorithm.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a run; accepted only when idle or done |
| mode | input | 2 | Algorithm: 0 march ones, 1 march zeros, 2 checkerboard, 3 walking |
| stop_on_fail | input | 1 | 1: halt at the first mismatch; 0: run to the end |
| mem_addr | output | ADDR_W | RAM address |
| mem_we | output | 1 | RAM write enable (a read when low during a run) |
| mem_wdata | output | DATA_W | RAM write data |
| mem_rdata | input | DATA_W | RAM read data, valid the cycle after a read |
| done | output | 1 | Run complete or halted |
| fail | output | 1 | At least one mismatch seen in this run |
| fail_addr | output | ADDR_W | Address of the first mismatch |

## Verification
On every cycle the embedded properties check several things: that the RAM is never written outside a run; that a read in the up-march is always followed by a write to the same address; that a halt lands in the done state on the next edge; that a busy run cannot be cut short; and that `fail` and `fail_addr` stay frozen once set. Only the bench's scenarios can show that each algorithm produces the exact address and data stream, including the checkerboard polarity and the pivot skipping of the walking test. The same applies to whether injected stuck-bit and aliased-write faults are caught at the right address, and whether stopping cuts the stream at the right cycle.

// File: rtl/mbist_pkg.sv
package mbist_pkg;

    typedef enum logic [1:0] {
        ALG_MARCH_ONES  = 2'd0,
        ALG_MARCH_ZEROS = 2'd1,
        ALG_CHECKER     = 2'd2,
        ALG_WALK        = 2'd3
    } alg_e;

    typedef enum logic [3:0] {
        PH_IDLE,
        PH_FILL,
        PH_UP_RD,
        PH_UP_WR,
        PH_DN_RD,
        PH_DN_WR,
        PH_CB_WR,
        PH_CB_RD,
        PH_WK_SET,
        PH_WK_RD,
        PH_WK_CHK,
        PH_WK_CLR,
        PH_DRAIN,
        PH_DONE
    } phase_e;

    typedef enum logic [1:0] {
        OP_NONE,
        OP_READ,
        OP_WRITE
    } op_kind_e;

    function automatic logic phase_busy(phase_e p);
        return !(p == PH_IDLE || p == PH_DONE);
    endfunction

endpackage

// File: rtl/mbist_seq.sv
module mbist_seq
    import mbist_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  alg_e              alg,
    input  logic              halt,
    output op_kind_e          op_kind,
    output logic [ADDR_W-1:0] op_addr,
    output logic [DATA_W-1:0] op_data,
    output logic              busy,
    output logic              done
);

    localparam logic [ADDR_W-1:0] LAST = '1;
    localparam logic [ADDR_W-1:0] ZERO = '0;
    localparam logic [ADDR_W-1:0] ONE  = ADDR_W'(1);
    localparam logic [ADDR_W-1:0] TWO  = ADDR_W'(2);
    localparam logic [ADDR_W-1:0] PENULT = LAST - ONE;

    phase_e            phase;
    alg_e              alg_q;
    logic [ADDR_W-1:0] addr_q;
    logic [ADDR_W-1:0] pivot_q;
    logic              pass_q;

    logic [DATA_W-1:0] bg;
    logic [DATA_W-1:0] cb_even;
    logic [DATA_W-1:0] cb_word;
    logic              rd_last;

    // even-address checkerboard word: bit 0 set, alternating upward
    for (genvar b = 0; b < DATA_W; b++) begin : g_cb
        assign cb_even[b] = ((b % 2) == 0) ? 1'b1 : 1'b0;
    end

    always_comb begin
        case (alg_q)
            ALG_MARCH_ZEROS: bg = '1;
            ALG_WALK:        bg = pass_q ? '1 : '0;
            default:         bg = '0;
        endcase
    end

    assign cb_word = (addr_q[0] ? ~cb_even : cb_even) ^ {DATA_W{pass_q}};
    assign rd_last = (addr_q == LAST) || (addr_q == PENULT && pivot_q == LAST);

    always_comb begin
        op_kind = OP_NONE;
        op_addr = addr_q;
        op_data = '0;
        case (phase)
            PH_FILL:   begin op_kind = OP_WRITE; op_data = bg;      end
            PH_UP_RD:  begin op_kind = OP_READ;  op_data = bg;      end
            PH_UP_WR:  begin op_kind = OP_WRITE; op_data = ~bg;     end
            PH_DN_RD:  begin op_kind = OP_READ;  op_data = ~bg;     end
            PH_DN_WR:  begin op_kind = OP_WRITE; op_data = bg;      end
            PH_CB_WR:  begin op_kind = OP_WRITE; op_data = cb_word; end
            PH_CB_RD:  begin op_kind = OP_READ;  op_data = cb_word; end
            PH_WK_SET: begin op_kind = OP_WRITE; op_addr = pivot_q; op_data = ~bg; end
            PH_WK_RD:  begin op_kind = OP_READ;  op_data = bg;      end
            PH_WK_CHK: begin op_kind = OP_READ;  op_addr = pivot_q; op_data = ~bg; end
            PH_WK_CLR: begin op_kind = OP_WRITE; op_addr = pivot_q; op_data = bg;  end
            default:   op_addr = ZERO;
        endcase
    end

    assign busy = phase_busy(phase);
    assign done = (phase == PH_DONE);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase   <= PH_IDLE;
            alg_q   <= ALG_MARCH_ONES;
            addr_q  <= ZERO;
            pivot_q <= ZERO;
            pass_q  <= 1'b0;
        end else if (halt && busy) begin
            phase <= PH_DONE;
        end else begin
            case (phase)
                PH_IDLE, PH_DONE: begin
                    if (start) begin
                        alg_q   <= alg;
                        addr_q  <= ZERO;
                        pivot_q <= ZERO;
                        pass_q  <= 1'b0;
                        phase   <= (alg == ALG_CHECKER) ? PH_CB_WR : PH_FILL;
                    end
                end
                PH_FILL: begin
                    if (addr_q == LAST) begin
                        addr_q <= ZERO;
                        phase  <= (alg_q == ALG_WALK) ? PH_WK_SET : PH_UP_RD;
                    end else begin
                        addr_q <= addr_q + ONE;
                    end
                end
                PH_UP_RD: phase <= PH_UP_WR;
                PH_UP_WR: begin
                    if (addr_q == LAST) begin
                        phase <= PH_DN_RD;
                    end else begin
                        addr_q <= addr_q + ONE;
                        phase  <= PH_UP_RD;
                    end
                end
                PH_DN_RD: phase <= PH_DN_WR;
                PH_DN_WR: begin
                    if (addr_q == ZERO) begin
                        phase <= PH_DRAIN;
                    end else begin
                        addr_q <= addr_q - ONE;
                        phase  <= PH_DN_RD;
                    end
                end
                PH_CB_WR: begin
                    if (addr_q == LAST) begin
                        addr_q <= ZERO;
                        phase  <= PH_CB_RD;
                    end else begin
                        addr_q <= addr_q + ONE;
                    end
                end
                PH_CB_RD: begin
                    if (addr_q == LAST) begin
                        addr_q <= ZERO;
                        if (pass_q) begin
                            phase <= PH_DRAIN;
                        end else begin
                            pass_q <= 1'b1;
                            phase  <= PH_CB_WR;
                        end
                    end else begin
                        addr_q <= addr_q + ONE;
                    end
                end
                PH_WK_SET: begin
                    addr_q <= (pivot_q == ZERO) ? ONE : ZERO;
                    phase  <= PH_WK_RD;
                end
                PH_WK_RD: begin
                    if (rd_last) begin
                        phase <= PH_WK_CHK;
                    end else if (addr_q + ONE == pivot_q) begin
                        addr_q <= addr_q + TWO;
                    end else begin
                        addr_q <= addr_q + ONE;
                    end
                end
                PH_WK_CHK: phase <= PH_WK_CLR;
                PH_WK_CLR: begin
                    if (pivot_q == LAST) begin
                        pivot_q <= ZERO;
                        addr_q  <= ZERO;
                        if (pass_q) begin
                            phase <= PH_DRAIN;
                        end else begin
                            pass_q <= 1'b1;
                            phase  <= PH_FILL;
                        end
                    end else begin
                        pivot_q <= pivot_q + ONE;
                        phase   <= PH_WK_SET;
                    end
                end
                PH_DRAIN: phase <= PH_DONE;
                default:  phase <= PH_IDLE;
            endcase
        end
    end

    // R2
    up_pair_chk: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_UP_RD && !halt) |=> (phase == PH_UP_WR && $stable(addr_q)));

    // R9
    busy_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && phase != PH_DRAIN && !halt) |=> busy);

    // R8
    halt_stop_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && halt) |=> (done && op_kind == OP_NONE));

endmodule

// File: rtl/mbist_cmp.sv
module mbist_cmp #(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  logic              op_rd,
    input  logic [ADDR_W-1:0] op_addr,
    input  logic [DATA_W-1:0] op_exp,
    input  logic [DATA_W-1:0] rdata,
    input  logic              stop_on_fail,
    output logic              halt,
    output logic              fail,
    output logic [ADDR_W-1:0] fail_addr
);

    typedef struct packed {
        logic              vld;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] exp;
    } rd_pipe_t;

    rd_pipe_t pipe;
    logic     mismatch;

    assign mismatch = pipe.vld && (rdata != pipe.exp);
    assign halt     = mismatch && stop_on_fail;

    always_ff @(posedge clk) begin
        if (rst) begin
            pipe      <= '0;
            fail      <= 1'b0;
            fail_addr <= '0;
        end else begin
            pipe.vld  <= op_rd && !halt;
            pipe.addr <= op_addr;
            pipe.exp  <= op_exp;
            if (clear) begin
                fail      <= 1'b0;
                fail_addr <= '0;
            end else if (mismatch && !fail) begin
                fail      <= 1'b1;
                fail_addr <= pipe.addr;
            end
        end
    end

    // R7
    first_fail_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (fail && !clear) |=> (fail && $stable(fail_addr)));

endmodule

// File: rtl/mem_bist_ctrl.sv
module mem_bist_ctrl
    import mbist_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [1:0]        mode,
    input  logic              stop_on_fail,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_we,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              done,
    output logic              fail,
    output logic [ADDR_W-1:0] fail_addr
);

    op_kind_e          op_kind;
    logic [ADDR_W-1:0] op_addr;
    logic [DATA_W-1:0] op_data;
    logic              busy;
    logic              halt;
    logic              clear;

    assign clear = start && !busy;

    mbist_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_seq (
        .clk     (clk),
        .rst     (rst),
        .start   (start),
        .alg     (alg_e'(mode)),
        .halt    (halt),
        .op_kind (op_kind),
        .op_addr (op_addr),
        .op_data (op_data),
        .busy    (busy),
        .done    (done)
    );

    mbist_cmp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_cmp (
        .clk          (clk),
        .rst          (rst),
        .clear        (clear),
        .op_rd        (op_kind == OP_READ),
        .op_addr      (op_addr),
        .op_exp       (op_data),
        .rdata        (mem_rdata),
        .stop_on_fail (stop_on_fail),
        .halt         (halt),
        .fail         (fail),
        .fail_addr    (fail_addr)
    );

    assign mem_addr  = op_addr;
    assign mem_we    = (op_kind == OP_WRITE);
    assign mem_wdata = mem_we ? op_data : '0;

    // R6
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !mem_we);

    // R1
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (!done && !fail && !mem_we));

endmodule

// File: tb/test_mem_bist_ctrl.sv
module test_mem_bist_ctrl;

    localparam int AW = 4;
    localparam int DW = 8;
    localparam int N  = 1 << AW;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic [1:0]    mode = 2'd0;
    logic          stop_on_fail = 1'b0;
    logic [AW-1:0] mem_addr;
    logic          mem_we;
    logic [DW-1:0] mem_wdata;
    logic [DW-1:0] mem_rdata = '0;
    logic          done;
    logic          fail;
    logic [AW-1:0] fail_addr;

    int n_chk = 0;
    int n_bad = 0;

    // fault injection: 0 none, 1 stuck bit at fa, 2 write to fa also lands on fa2
    int fty = 0;
    int fa  = 0;
    int fa2 = 0;
    int fbit = 0;
    logic fval = 1'b0;

    logic [DW-1:0] ram [N];

    logic     q_we  [$];
    int       q_adr [$];
    logic [DW-1:0] q_dat [$];

    always #4 clk = ~clk;

    mem_bist_ctrl #(.ADDR_W(AW), .DATA_W(DW)) i_mem_bist_ctrl (
        .clk(clk), .rst(rst), .start(start), .mode(mode),
        .stop_on_fail(stop_on_fail), .mem_addr(mem_addr), .mem_we(mem_we),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .done(done),
        .fail(fail), .fail_addr(fail_addr)
    );

    function automatic logic [DW-1:0] faulty(input int a, input logic [DW-1:0] d);
        logic [DW-1:0] r = d;
        if (fty == 1 && a == fa) r[fbit] = fval;
        return r;
    endfunction

    always @(posedge clk) begin
        if (mem_we) begin
            ram[mem_addr] <= faulty(int'(mem_addr), mem_wdata);
            if (fty == 2 && int'(mem_addr) == fa) ram[fa2] <= faulty(fa2, mem_wdata);
        end
        mem_rdata <= ram[mem_addr];
    end

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic push(input logic we, input int a, input logic [DW-1:0] d);
        q_we.push_back(we);
        q_adr.push_back(a);
        q_dat.push_back(d);
    endtask

    function automatic logic [DW-1:0] cbw(input int a, input logic inv);
        logic [DW-1:0] w = (a % 2 == 0) ? {(DW/2){2'b01}} : {(DW/2){2'b10}};
        return inv ? ~w : w;
    endfunction

    task automatic gen(input int alg);
        logic [DW-1:0] bg;
        q_we.delete(); q_adr.delete(); q_dat.delete();
        if (alg == 0 || alg == 1) begin
            bg = (alg == 1) ? '1 : '0;
            for (int a = 0; a < N; a++) push(1'b1, a, bg);
            for (int a = 0; a < N; a++) begin push(1'b0, a, bg); push(1'b1, a, ~bg); end
            for (int a = N - 1; a >= 0; a--) begin push(1'b0, a, ~bg); push(1'b1, a, bg); end
        end else if (alg == 2) begin
            for (int p = 0; p < 2; p++) begin
                for (int a = 0; a < N; a++) push(1'b1, a, cbw(a, p[0]));
                for (int a = 0; a < N; a++) push(1'b0, a, cbw(a, p[0]));
            end
        end else begin
            for (int p = 0; p < 2; p++) begin
                bg = (p == 1) ? '1 : '0;
                for (int a = 0; a < N; a++) push(1'b1, a, bg);
                for (int i = 0; i < N; i++) begin
                    push(1'b1, i, ~bg);
                    for (int j = 0; j < N; j++) if (j != i) push(1'b0, j, bg);
                    push(1'b0, i, ~bg);
                    push(1'b1, i, bg);
                end
            end
        end
    endtask

    task automatic run(input int alg, input logic stop, input int pulse_at, input string req);
        logic [DW-1:0] refm [N];
        int r = -1;
        int len;
        int endc;
        gen(alg);
        len = q_we.size();
        for (int a = 0; a < N; a++) refm[a] = '0;
        for (int k = 0; k < len; k++) begin
            if (q_we[k]) begin
                refm[q_adr[k]] = faulty(q_adr[k], q_dat[k]);
                if (fty == 2 && q_adr[k] == fa) refm[fa2] = faulty(fa2, q_dat[k]);
            end else if (r < 0 && refm[q_adr[k]] != q_dat[k]) begin
                r = k;
            end
        end
        endc = (stop && r >= 0) ? r + 2 : len + 1;
        mode = alg[1:0];
        stop_on_fail = stop;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int c = 0; c < endc; c++) begin
            if (c < len) begin
                chk(mem_we == q_we[c], req, int'(mem_we), int'(q_we[c]));
                chk(int'(mem_addr) == q_adr[c], req, int'(mem_addr), q_adr[c]);
                if (q_we[c]) chk(mem_wdata == q_dat[c], req, int'(mem_wdata), int'(q_dat[c]));
            end else begin
                chk(!mem_we, "R6 drain", int'(mem_we), 0);
            end
            chk(!done, "R6 busy", int'(done), 0);
            // R9: a start pulse mid-run with another mode must not disturb the stream
            start = (c == pulse_at);
            if (c == pulse_at) mode = ~alg[1:0];
            @(negedge clk);
        end
        start = 1'b0;
        chk(done, {req, " R6 done"}, int'(done), 1);
        chk(!mem_we, {req, " R8 quiet"}, int'(mem_we), 0);
        chk(fail == (r >= 0), {req, " R7 fail"}, int'(fail), int'(r >= 0));
        if (r >= 0) chk(int'(fail_addr) == q_adr[r], {req, " R7 addr"}, int'(fail_addr), q_adr[r]);
        @(negedge clk);
    endtask

    task automatic summary;
        $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    endtask

    initial begin
        #(150000 * 8);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: state while and right after reset
        chk(!done && !fail && !mem_we, "R1 in reset", int'({done, fail, mem_we}), 0);
        rst = 1'b0;
        @(negedge clk);
        chk(!done && !fail && !mem_we, "R1 after reset", int'({done, fail, mem_we}), 0);
        @(negedge clk);

        fty = 0;
        run(0, 1'b1, -1, "R2 march ones");
        run(1, 1'b0, 20, "R3 R9 march zeros");
        run(2, 1'b1, -1, "R4 checker");
        run(3, 1'b1, -1, "R5 walk");

        fty = 1; fa = 5; fbit = 2; fval = 1'b1;
        run(0, 1'b1, -1, "R8 stuck march stop");

        fty = 2; fa = 3; fa2 = 9;
        run(3, 1'b0, -1, "R7 alias walk");

        fty = 1; fa = 6; fbit = 0; fval = 1'b0;
        run(2, 1'b0, 40, "R7 stuck checker");

        fty = 0;
        run(1, 1'b1, -1, "R9 restart clears fail");

        summary();
        $finish;
    end

endmodule